// File: doc/BRIEF.md
# Interrupt Gating Unit with Status Save Stack

This block sits beside an instruction sequencer and decides which interrupt, if any, may be taken. Raw requests and software forces are latched into a pending register. A per-source enable mask filters the pending register, and a single global enable flag filters it again. The lowest-numbered eligible source is offered to the sequencer as a request with a binary vector. Turning the global flag off hides every source. The mask register keeps its contents while the flag is off, so turning the flag back on restores exactly the earlier set of enabled sources.

The unit also holds a small last-in, first-out stack of status snapshots. Each entry holds the interrupt mask, a mode word and an arithmetic status word. Taking an interrupt pushes a snapshot. A return strobe pops one and restores all three registers. Software can also push and pop snapshots explicitly. A push into a full stack is ignored, and so is a pop from an empty stack. Either one sets an error flag that stays set until reset.

Top module: `irq_gate_sts`

## Requirements
- R1: After reset the global enable is on, the mask, mode and arithmetic registers and all pending bits are zero, `irq_req` is 0, `stk_empty` is 1, `stk_full` is 0 and `stk_err` is 0.
- R2: A cycle with `gbl_dis` high turns the global enable off from the next cycle. While it is off, `irq_req` stays 0 for every source, including the highest-numbered source (the power-down source). `mask_o` is left unchanged.
- R3: A cycle with `gbl_ena` high turns the global enable back on. From the next cycle, any pending source whose mask bit is 1 is requested again. A pending source whose mask bit is 0 is never requested. If both strobes are high in the same cycle, the disable wins.
- R4: A 1 on `irq_raw[i]` at a clock edge sets pending bit i, and `irq_req` can rise in the following cycle. The bit stays pending after the raw input drops, until it is cleared or serviced.
- R5: When several eligible sources are pending, `irq_vec` gives the lowest index among them.
- R6: A cycle with `frc_we` high sets pending bit i where `frc_set[i]` is 1 and clears it where `frc_clr[i]` is 1. A clear takes priority over a set or a raw request arriving in the same cycle.
- R7: When `svc_ack` is high while `irq_req` is 1, the current mask, mode and arithmetic values are pushed as one entry, and the pending bit of the winning source is cleared. When `svc_ack` is high while `irq_req` is 0, it has no effect.
- R8: A cycle with `rti` high pops the top entry and restores the mask, mode and arithmetic registers from it on the next edge.
- R9: `push_sts` and `pop_sts` push and pop the same stack that R7 and R8 use.
- R10: `stk_full` is 1 exactly when the stack holds DEPTH entries. `stk_empty` is 1 exactly when it holds none.
- R11: A push into a full stack and a pop from an empty stack change neither the stack nor the registers. Either one sets `stk_err`, which then stays at 1 until reset.
- R12: At most one stack operation happens per cycle. The order of precedence is: a taken service, then `rti` or `pop_sts`, then `push_sts`. A restore by a pop takes priority over a write to the mask, mode or arithmetic register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | N_SRC | Raw interrupt requests, sampled each edge |
| gbl_ena | input | 1 | Global enable strobe |
| gbl_dis | input | 1 | Global disable strobe |
| mask_we | input | 1 | Mask register write |
| mask_wdata | input | N_SRC | Mask write data, bit i = 1 enables source i |
| frc_we | input | 1 | Force/clear register write |
| frc_set | input | N_SRC | Sources to force pending |
| frc_clr | input | N_SRC | Sources to clear from pending |
| mode_we | input | 1 | Mode word write |
| mode_wdata | input | MODE_W | Mode write data |
| arith_we | input | 1 | Arithmetic status write |
| arith_wdata | input | ARITH_W | Arithmetic status write data |
| svc_ack | input | 1 | Sequencer takes the offered interrupt |
| rti | input | 1 | Return from interrupt strobe |
| push_sts | input | 1 | Explicit status push |
| pop_sts | input | 1 | Explicit status pop |
| irq_req | output | 1 | An eligible interrupt is pending |
| irq_vec | output | VEC_W | Index of the winning source |
| mask_o | output | N_SRC | Current mask register |
| mode_o | output | MODE_W | Current mode word |
| arith_o | output | ARITH_W | Current arithmetic status word |
| stk_empty | output | 1 | Status stack holds no entry |
| stk_full | output | 1 | Status stack holds DEPTH entries |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench uses the default build: ten sources, a stack depth of four and 8-bit mode and arithmetic words. With a depth of four, the stack fills after only four pushes, so the overflow case and the drain back to empty through underflow each take a handful of cycles. With ten sources, index 9 acts as the power-down source, so the bench can show the global disable hiding it. The simultaneous-strobe orderings are driven in single cycles and checked through the restored register values and the stack flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_raw,
  input  logic             gbl_ena,
  input  logic             gbl_dis,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             restore_en,
  input  logic [N_SRC-1:0] restore_mask,
  input  logic             frc_we,
  input  logic [N_SRC-1:0] frc_set,
  input  logic [N_SRC-1:0] frc_clr,
  input  logic [N_SRC-1:0] ack_oh,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] elig_o
);
  logic             gie_q, gie_d, gie_en;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic             mask_en;
  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] set_v, clr_v;

  // global enable: disable dominates
  always_comb begin
    gie_en = gbl_ena | gbl_dis;
    gie_d  = gbl_dis ? 1'b0 : 1'b1;
  end

  // mask: restore from stack dominates a write
  always_comb begin
    mask_en = restore_en | mask_we;
    mask_d  = restore_en ? restore_mask : mask_wdata;
  end

  always_comb begin
    set_v = irq_raw | (frc_we ? frc_set : '0);
    clr_v = ack_oh  | (frc_we ? frc_clr : '0);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_pend
    always_comb pend_d[i] = (pend_q[i] | set_v[i]) & ~clr_v[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b1;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (gie_en)  gie_q  <= gie_d;
      if (mask_en) mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign mask_o = mask_q;
  assign elig_o = pend_q & mask_q & {N_SRC{gie_q}};

  AST_GDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> (elig_o == '0)); // R2
  AST_DIS_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (gbl_dis && !mask_we && !restore_en) |=> $stable(mask_q)); // R2
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_we && (frc_clr != '0)) |=> ((pend_q & $past(frc_clr)) == '0)); // R6
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC = 10,
  parameter int VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] elig,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic [N_SRC-1:0] win_oh
);
  // scan from the top so the lowest index is written last and wins
  always_comb begin
    vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) vec = VEC_W'(i);
    end
  end

  // lowest set bit isolated
  always_comb win_oh = elig & (~elig + N_SRC'(1));
  assign req = |elig;

  AST_VEC_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> elig[vec]); // R5
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (req == (win_oh != '0))); // R5
endmodule

// File: rtl/irq_sts_stack.sv
module irq_sts_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ENT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  input  logic [ENT_W-1:0] push_data,
  output logic [ENT_W-1:0] top_data,
  output logic             pop_ok,
  output logic             empty,
  output logic             full,
  output logic             err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;
  logic             push_ok, bad_op;
  logic [CW-1:0]    cnt_m1;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CW'(DEPTH));
    push_ok = (op == STK_PUSH) && !full;
    pop_ok  = (op == STK_POP)  && !empty;
    bad_op  = ((op == STK_PUSH) && full) || ((op == STK_POP) && empty);
    cnt_m1  = cnt_q - CW'(1);
    cnt_en  = push_ok | pop_ok;
    cnt_d   = push_ok ? cnt_q + CW'(1) : cnt_m1;
    err_d   = err_q | bad_op;
  end

  assign top_data = mem[AW'(cnt_m1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  // storage without reset; only entries below the count are read
  always_ff @(posedge clk) begin
    if (push_ok) mem[AW'(cnt_q)] <= push_data;
  end

  assign err = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R10
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH && full) |=> ($stable(cnt_q) && err_q)); // R11
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP && empty) |=> ($stable(cnt_q) && err_q)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R11
endmodule

// File: rtl/irq_gate_sts.sv
module irq_gate_sts
  import irq_pkg::*;
#(
  parameter int N_SRC   = 10,
  parameter int DEPTH   = 4,
  parameter int MODE_W  = 8,
  parameter int ARITH_W = 8,
  parameter int VEC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   irq_raw,
  input  logic               gbl_ena,
  input  logic               gbl_dis,
  input  logic               mask_we,
  input  logic [N_SRC-1:0]   mask_wdata,
  input  logic               frc_we,
  input  logic [N_SRC-1:0]   frc_set,
  input  logic [N_SRC-1:0]   frc_clr,
  input  logic               mode_we,
  input  logic [MODE_W-1:0]  mode_wdata,
  input  logic               arith_we,
  input  logic [ARITH_W-1:0] arith_wdata,
  input  logic               svc_ack,
  input  logic               rti,
  input  logic               push_sts,
  input  logic               pop_sts,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [N_SRC-1:0]   mask_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic [ARITH_W-1:0] arith_o,
  output logic               stk_empty,
  output logic               stk_full,
  output logic               stk_err
);
  localparam int ENT_W = N_SRC + MODE_W + ARITH_W;

  logic [N_SRC-1:0]   elig, win_oh, ack_oh;
  logic               svc_take, restore_en;
  stk_op_e            op;
  logic [ENT_W-1:0]   push_data, top_data;
  logic               pop_ok;
  logic [N_SRC-1:0]   rst_mask;
  logic [MODE_W-1:0]  rst_mode, mode_q, mode_d;
  logic [ARITH_W-1:0] rst_arith, arith_q, arith_d;
  logic               mode_en, arith_en;

  // one stack operation per cycle
  always_comb begin
    svc_take = svc_ack & irq_req;
    if (svc_take)            op = STK_PUSH;
    else if (rti | pop_sts)  op = STK_POP;
    else if (push_sts)       op = STK_PUSH;
    else                     op = STK_IDLE;
    ack_oh = svc_take ? win_oh : '0;
  end

  assign push_data  = {mask_o, mode_q, arith_q};
  assign {rst_mask, rst_mode, rst_arith} = top_data;
  assign restore_en = pop_ok;

  irq_src_ctrl #(.N_SRC(N_SRC)) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_raw      (irq_raw),
    .gbl_ena      (gbl_ena),
    .gbl_dis      (gbl_dis),
    .mask_we      (mask_we),
    .mask_wdata   (mask_wdata),
    .restore_en   (restore_en),
    .restore_mask (rst_mask),
    .frc_we       (frc_we),
    .frc_set      (frc_set),
    .frc_clr      (frc_clr),
    .ack_oh       (ack_oh),
    .mask_o       (mask_o),
    .elig_o       (elig)
  );

  irq_prio_enc #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .elig   (elig),
    .req    (irq_req),
    .vec    (irq_vec),
    .win_oh (win_oh)
  );

  irq_sts_stack #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .push_data (push_data),
    .top_data  (top_data),
    .pop_ok    (pop_ok),
    .empty     (stk_empty),
    .full      (stk_full),
    .err       (stk_err)
  );

  // mode and arithmetic words: restore dominates a write
  always_comb begin
    mode_en  = restore_en | mode_we;
    mode_d   = restore_en ? rst_mode : mode_wdata;
    arith_en = restore_en | arith_we;
    arith_d  = restore_en ? rst_arith : arith_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      arith_q <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (arith_en) arith_q <= arith_d;
    end
  end

  assign mode_o  = mode_q;
  assign arith_o = arith_q;

  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && irq_req && !stk_full) |=> !stk_empty); // R7
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && !irq_req && !rti && !pop_sts && !push_sts) |=> ($stable(stk_empty) && $stable(stk_full))); // R7
  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_en && mode_we) |=> (mode_q == $past(rst_mode))); // R12
endmodule

// File: tb/tb_irq_gate_sts.sv
module tb_irq_gate_sts;
  localparam int N = 10;
  localparam int D = 4;
  localparam int MW = 8;
  localparam int AW = 8;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] irq_raw, mask_wdata, frc_set, frc_clr;
  logic gbl_ena, gbl_dis, mask_we, frc_we, mode_we, arith_we;
  logic [MW-1:0] mode_wdata;
  logic [AW-1:0] arith_wdata;
  logic svc_ack, rti, push_sts, pop_sts;
  logic irq_req;
  logic [VW-1:0] irq_vec;
  logic [N-1:0] mask_o;
  logic [MW-1:0] mode_o;
  logic [AW-1:0] arith_o;
  logic stk_empty, stk_full, stk_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_gate_sts dut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .gbl_ena(gbl_ena), .gbl_dis(gbl_dis),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .frc_we(frc_we), .frc_set(frc_set),
    .frc_clr(frc_clr), .mode_we(mode_we), .mode_wdata(mode_wdata), .arith_we(arith_we),
    .arith_wdata(arith_wdata), .svc_ack(svc_ack), .rti(rti), .push_sts(push_sts),
    .pop_sts(pop_sts), .irq_req(irq_req), .irq_vec(irq_vec), .mask_o(mask_o),
    .mode_o(mode_o), .arith_o(arith_o), .stk_empty(stk_empty), .stk_full(stk_full),
    .stk_err(stk_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_raw = '0; gbl_ena = 0; gbl_dis = 0; mask_we = 0; mask_wdata = '0;
    frc_we = 0; frc_set = '0; frc_clr = '0; mode_we = 0; mode_wdata = '0;
    arith_we = 0; arith_wdata = '0; svc_ack = 0; rti = 0; push_sts = 0; pop_sts = 0;
  endtask

  // one clock with whatever is driven, then strobes return to idle
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic set_mask(logic [N-1:0] m);
    mask_we = 1; mask_wdata = m; tick();
  endtask

  task automatic clear_pend();
    frc_we = 1; frc_clr = '1; tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irq_req", irq_req, 0);
    check("R1 mask", mask_o, 0);
    check("R1 mode", mode_o, 0);
    check("R1 arith", arith_o, 0);
    check("R1 empty", stk_empty, 1);
    check("R1 full", stk_full, 0);
    check("R1 err", stk_err, 0);
    // pending exists but mask zero: no request
    frc_we = 1; frc_set = 10'h001; tick();
    check("R3 masked-off not requested", irq_req, 0);
    // underflow on empty stack
    mode_we = 1; mode_wdata = 8'h42; tick();
    pop_sts = 1; tick();
    check("R11 underflow sets err", stk_err, 1);
    check("R11 underflow keeps mode", mode_o, 8'h42);
    check("R11 underflow keeps empty", stk_empty, 1);
    tick();
    check("R11 err sticky", stk_err, 1);
    do_reset();
  endtask

  task automatic t_raw_latch();
    set_mask('1);
    irq_raw = 10'h008; tick();
    check("R4 request after raw pulse", irq_req, 1);
    check("R4 vector", irq_vec, 3);
    tick();
    check("R4 pending persists", irq_req, 1);
    irq_raw = 10'h0A0; tick();
    check("R5 lowest wins", irq_vec, 3);
    frc_we = 1; frc_clr = 10'h008; tick();
    check("R5 next lowest", irq_vec, 5);
    clear_pend();
  endtask

  task automatic t_force();
    frc_we = 1; frc_set = 10'h004; tick();
    check("R6 force sets pending", irq_vec, 2);
    frc_we = 1; frc_set = 10'h002; frc_clr = 10'h002; tick();
    check("R6 clear beats set", irq_vec, 2);
    irq_raw = 10'h001; frc_we = 1; frc_clr = 10'h001; tick();
    check("R6 clear beats raw", irq_vec, 2);
    frc_we = 1; frc_clr = 10'h004; tick();
    check("R6 clear empties", irq_req, 0);
  endtask

  task automatic t_global();
    frc_we = 1; frc_set = 10'h200; tick();
    check("R2 pre: power-down src requested", irq_vec, 9);
    gbl_dis = 1; tick();
    check("R2 disable hides power-down src", irq_req, 0);
    check("R2 mask unchanged", mask_o, 10'h3FF);
    gbl_ena = 1; gbl_dis = 1; tick();
    check("R3 disable wins over enable", irq_req, 0);
    gbl_ena = 1; tick();
    check("R3 enable restores request", irq_req, 1);
    check("R3 enable vector", irq_vec, 9);
    set_mask(10'h1FF);
    check("R3 masked bit not requested", irq_req, 0);
    set_mask('1);
    clear_pend();
  endtask

  task automatic t_service();
    mode_we = 1; mode_wdata = 8'h5A; arith_we = 1; arith_wdata = 8'h3C; tick();
    svc_ack = 1; tick();
    check("R7 idle ack no push", stk_empty, 1);
    frc_we = 1; frc_set = 10'h210; tick();
    svc_ack = 1; tick();
    check("R7 ack pushes", stk_empty, 0);
    check("R7 winner cleared", irq_vec, 9);
    mask_we = 1; mask_wdata = 10'h00F; mode_we = 1; mode_wdata = 8'h11;
    arith_we = 1; arith_wdata = 8'h22; tick();
    rti = 1; tick();
    check("R8 mask restored", mask_o, 10'h3FF);
    check("R8 mode restored", mode_o, 8'h5A);
    check("R8 arith restored", arith_o, 8'h3C);
    check("R8 stack empty after rti", stk_empty, 1);
    clear_pend();
  endtask

  task automatic t_stack();
    for (int k = 1; k <= D; k++) begin
      mode_we = 1; mode_wdata = 8'(k); tick();
      push_sts = 1; tick();
    end
    check("R10 full at depth", stk_full, 1);
    check("R9 not empty", stk_empty, 0);
    mode_we = 1; mode_wdata = 8'h99; tick();
    push_sts = 1; tick();
    check("R11 overflow sets err", stk_err, 1);
    check("R11 overflow still full", stk_full, 1);
    for (int k = D; k >= 1; k--) begin
      pop_sts = 1; tick();
      check("R9 pop order", mode_o, k);
    end
    check("R10 empty after drain", stk_empty, 1);
    check("R11 err sticky", stk_err, 1);
  endtask

  task automatic t_order();
    do_reset();
    mode_we = 1; mode_wdata = 8'h77; tick();
    push_sts = 1; tick();
    rti = 1; mode_we = 1; mode_wdata = 8'h99; tick();
    check("R12 restore beats write", mode_o, 8'h77);
    set_mask('1);
    frc_we = 1; frc_set = 10'h002; tick();
    svc_ack = 1; push_sts = 1; tick();
    check("R12 svc+push single entry", stk_empty, 0);
    pop_sts = 1; tick();
    check("R12 one pop empties", stk_empty, 1);
    check("R12 no err", stk_err, 0);
    mode_we = 1; mode_wdata = 8'h10; tick();
    push_sts = 1; tick();
    pop_sts = 1; push_sts = 1; tick();
    check("R12 pop beats push", stk_empty, 1);
  endtask

  initial begin
    rst_n = 0;
    idle();
    t_reset();
    t_raw_latch();
    t_force();
    t_global();
    t_service();
    t_stack();
    t_order();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule